// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the byte-wide register front end of an eight-line priority interrupt controller. It decodes host writes and reads on a small synchronous bus and keeps the state that the rest of the controller uses: the line mask, the in-service set, the rotating priority base, the vector base and the mode flags (auto end-of-interrupt, rotate on auto end-of-interrupt, special mask, special fully-nested). A short sequencer steps through the initialization words. Writes to the command address are split by bit pattern into an initialization start, a "mode" command (poll, readback select, special mask) and an "action" command (end-of-interrupt forms and priority rotation).

The current request vector comes in from the request-capture logic on `req_i`, which is outside this block. In poll mode the next read acknowledges the winning line. The read returns it and the block pulses `ack_o` with the line number, so the capture logic can retire an edge request. A separate edge/level trigger register is written through a fixed per-instance mask and drives `trig_o`.

Top module: `pic_regif`

## Requirements
- R1: After reset, mask, in-service set, priority base, vector base, trigger register and all mode flags are zero. The sequencer is idle and a plain read at address 0 returns `req_i`.
- R2: A write to address 0 with bit 4 set clears mask, in-service set, priority base, poll, readback select and all mode flags. It leaves the trigger register unchanged. It records bit 0 as "fourth word needed" and bit 1 as "single", and the sequencer then expects the second word.
- R3: Address 1 writes are routed by the sequencer. When idle they load the mask. The second word loads the vector base as data AND 0xF8. From there the sequencer goes to the fourth-word step if single and the fourth word is needed, to idle if single without it, and otherwise to the third-word step. The third word is discarded and leads to the fourth-word step or to idle, following the same flag.
- R4: The fourth word sets special fully-nested mode from bit 4 and auto end-of-interrupt from bit 1, then returns the sequencer to idle.
- R5: An address 0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. If bit 1 is set, bit 0 picks the readback (1 = in-service, 0 = requests). If bit 6 is set, bit 5 becomes the special-mask flag.
- R6: An action command (bits 4 and 3 clear) with code bits[7:5] = 1 clears the in-service line of highest priority in the rotated order. It does nothing when no line is in service.
- R7: Code 5 works like code 1 and also sets the priority base to the cleared line + 1 (mod 8). When no line is in service, nothing changes.
- R8: Code 3 clears in-service line data[2:0]. Code 7 does the same and sets the base to that line + 1. Code 6 sets the base to data[2:0] + 1 (mod 8). Code 2 changes nothing.
- R9: Codes 0 and 4 clear and set the rotate-on-auto-EOI flag.
- R10: A read while poll is armed acknowledges the winner and disarms poll. The winner is the unmasked request of highest rotated priority, and it must beat the highest in-service line; while special mask is on, masked in-service lines are left out of that comparison. If the winner exists, the read returns 0x80 OR its line, `ack_o` pulses with the line, and the line is marked in service unless auto-EOI is on. Otherwise the read returns 0 and there is no acknowledge.
- R11: When a poll acknowledges while auto-EOI is on, the in-service set is left unchanged. If rotation is also on, the base becomes the line + 1; if not, the base is kept.
- R12: A write to address 2 stores data AND the instance's trigger mask (default 0xF8). A read at address 2 returns the stored value, and a read at address 1 returns the mask.
- R13: Read data and `ack_o` appear in the cycle after `rd_i`. A read that coincides with a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register address (0 command, 1 data, 2 trigger) |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| req_i | input | 8 | Current request vector from capture logic |
| rdata_o | output | 8 | Registered read data |
| ack_o | output | 1 | Poll acknowledge pulse |
| ack_line_o | output | 3 | Acknowledged line |
| mask_o | output | 8 | Line mask |
| isr_o | output | 8 | In-service set |
| prio_base_o | output | 3 | Line holding top priority |
| vec_base_o | output | 8 | Vector base |
| trig_o | output | 8 | Edge/level trigger register |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| spec_mask_o | output | 1 | Special mask mode |
| nested_o | output | 1 | Special fully-nested mode |

## Verification
The hardest case to reach is a set of several in-service lines under a rotated base. At that point a non-specific end-of-interrupt has to choose by rotated priority rather than by line index, and a poll can lose to an in-service line. The only port that sets in-service bits is a poll read. The stimulus therefore moves the base with code 6 and then polls a low-priority request, followed by a higher-priority one. This builds a two-line in-service set, which the rotating and specific end-of-interrupt codes then clear one line at a time. Special mask is reached the same way: a line is put in service, the mask is set over it, and a request that lost before now wins.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_W2   = 2'd1,
    SEQ_W3   = 2'd2,
    SEQ_W4   = 2'd3
  } seq_t;

  typedef enum logic [2:0] {
    ACT_ROT_OFF = 3'd0,
    ACT_NS_EOI  = 3'd1,
    ACT_NOP     = 3'd2,
    ACT_SP_EOI  = 3'd3,
    ACT_ROT_ON  = 3'd4,
    ACT_NS_ROT  = 3'd5,
    ACT_SET_PRI = 3'd6,
    ACT_SP_ROT  = 3'd7
  } act_t;
endpackage

// File: rtl/pic_prio_res.sv
module pic_prio_res
  import pic_pkg::*;
(
  input  logic [LINES-1:0] vec_i,
  input  logic [LW-1:0]    base_i,
  output logic             found_o,
  output logic [LW:0]      prio_o,
  output logic [LW-1:0]    line_o
);
  logic [LW-1:0] idx;

  always_comb begin
    found_o = 1'b0;
    prio_o  = (LW+1)'(LINES);
    line_o  = '0;
    idx     = '0;
    for (int p = LINES - 1; p >= 0; p--) begin
      idx = base_i + p[LW-1:0];
      if (vec_i[idx]) begin
        found_o = 1'b1;
        prio_o  = p[LW:0];
        line_o  = idx;
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic need4_i,
  input  logic single_i,
  input  logic step_i,
  output seq_t state_o
);
  logic need4_q, single_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o  <= SEQ_IDLE;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
    end else if (start_i) begin
      state_o  <= SEQ_W2;
      need4_q  <= need4_i;
      single_q <= single_i;
    end else if (step_i) begin
      case (state_o)
        SEQ_W2:  state_o <= single_q ? (need4_q ? SEQ_W4 : SEQ_IDLE) : SEQ_W3;
        SEQ_W3:  state_o <= need4_q ? SEQ_W4 : SEQ_IDLE;
        SEQ_W4:  state_o <= SEQ_IDLE;
        default: state_o <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_regif.sv
module pic_regif
  import pic_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [LINES-1:0] req_i,
  output logic [7:0]       rdata_o,
  output logic             ack_o,
  output logic [LW-1:0]    ack_line_o,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] isr_o,
  output logic [LW-1:0]    prio_base_o,
  output logic [7:0]       vec_base_o,
  output logic [LINES-1:0] trig_o,
  output logic             auto_eoi_o,
  output logic             rot_aeoi_o,
  output logic             spec_mask_o,
  output logic             nested_o
);
  localparam logic [7:0] VEC_MASK = 8'hFF << LW;

  seq_t seq_state;
  logic poll_q, rsel_q;

  wire  cmd_wr   = wr_i && (addr_i == 2'd0);
  wire  init_wr  = cmd_wr && wdata_i[4];
  wire  mode_wr  = cmd_wr && !wdata_i[4] && wdata_i[3];
  wire  act_wr   = cmd_wr && !wdata_i[4] && !wdata_i[3];
  wire  data_wr  = wr_i && (addr_i == 2'd1);
  wire  trig_wr  = wr_i && (addr_i == 2'd2);
  wire  rd_go    = rd_i && !wr_i;
  act_t act;
  assign act = act_t'(wdata_i[7:5]);

  logic [LINES-1:0] cur_vec;
  logic             req_found, cur_found, eoi_found;
  logic [LW:0]      req_prio, cur_prio, eoi_prio;
  logic [LW-1:0]    req_line, cur_line, eoi_line;

  assign cur_vec = spec_mask_o ? (isr_o & ~mask_o) : isr_o;

  pic_prio_res req_res_i (.vec_i(req_i & ~mask_o), .base_i(prio_base_o),
    .found_o(req_found), .prio_o(req_prio), .line_o(req_line));
  pic_prio_res cur_res_i (.vec_i(cur_vec), .base_i(prio_base_o),
    .found_o(cur_found), .prio_o(cur_prio), .line_o(cur_line));
  pic_prio_res eoi_res_i (.vec_i(isr_o), .base_i(prio_base_o),
    .found_o(eoi_found), .prio_o(eoi_prio), .line_o(eoi_line));

  wire poll_win = req_found && (req_prio < cur_prio);
  wire [LW-1:0] spec_line = wdata_i[LW-1:0];

  pic_init_seq seq_i (
    .clk(clk), .rst(rst), .start_i(init_wr), .need4_i(wdata_i[0]),
    .single_i(wdata_i[1]), .step_i(data_wr), .state_o(seq_state));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0; isr_o <= '0; prio_base_o <= '0; vec_base_o <= '0;
      trig_o <= '0; auto_eoi_o <= 1'b0; rot_aeoi_o <= 1'b0;
      spec_mask_o <= 1'b0; nested_o <= 1'b0; poll_q <= 1'b0; rsel_q <= 1'b0;
      rdata_o <= '0; ack_o <= 1'b0; ack_line_o <= '0;
    end else begin
      ack_o <= 1'b0;
      if (init_wr) begin
        mask_o <= '0; isr_o <= '0; prio_base_o <= '0;
        auto_eoi_o <= 1'b0; rot_aeoi_o <= 1'b0; spec_mask_o <= 1'b0;
        nested_o <= 1'b0; poll_q <= 1'b0; rsel_q <= 1'b0;
      end else if (mode_wr) begin
        if (wdata_i[2]) poll_q <= 1'b1;
        if (wdata_i[1]) rsel_q <= wdata_i[0];
        if (wdata_i[6]) spec_mask_o <= wdata_i[5];
      end else if (act_wr) begin
        case (act)
          ACT_ROT_OFF: rot_aeoi_o <= 1'b0;
          ACT_ROT_ON:  rot_aeoi_o <= 1'b1;
          ACT_NS_EOI, ACT_NS_ROT: if (eoi_found) begin
            isr_o[eoi_line] <= 1'b0;
            if (act == ACT_NS_ROT) prio_base_o <= eoi_line + 1'b1;
          end
          ACT_SP_EOI:  isr_o[spec_line] <= 1'b0;
          ACT_SET_PRI: prio_base_o <= spec_line + 1'b1;
          ACT_SP_ROT: begin
            isr_o[spec_line] <= 1'b0;
            prio_base_o      <= spec_line + 1'b1;
          end
          default: ;
        endcase
      end else if (data_wr) begin
        case (seq_state)
          SEQ_IDLE: mask_o <= wdata_i;
          SEQ_W2:   vec_base_o <= wdata_i & VEC_MASK;
          SEQ_W4: begin
            nested_o   <= wdata_i[4];
            auto_eoi_o <= wdata_i[1];
          end
          default: ;
        endcase
      end else if (trig_wr) begin
        trig_o <= wdata_i & TRIG_MASK;
      end else if (rd_go) begin
        if (poll_q) begin
          poll_q <= 1'b0;
          if (poll_win) begin
            rdata_o    <= {1'b1, {(7-LW){1'b0}}, req_line};
            ack_o      <= 1'b1;
            ack_line_o <= req_line;
            if (auto_eoi_o) begin
              if (rot_aeoi_o) prio_base_o <= req_line + 1'b1;
            end else begin
              isr_o[req_line] <= 1'b1;
            end
          end else begin
            rdata_o <= '0;
          end
        end else begin
          case (addr_i)
            2'd0:    rdata_o <= rsel_q ? isr_o : req_i;
            2'd1:    rdata_o <= mask_o;
            2'd2:    rdata_o <= trig_o;
            default: rdata_o <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pic_regif_chk.sv
module pic_regif_chk
  import pic_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [7:0]       rdata_o,
  input logic             ack_o,
  input logic [LW-1:0]    ack_line_o,
  input logic [LINES-1:0] mask_o,
  input logic [LINES-1:0] isr_o,
  input logic [LINES-1:0] trig_o
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isr_o == '0 && mask_o == '0 && trig_o == '0 && !ack_o));

  a_r2_init_clears: assert property (@(posedge clk) disable iff (rst)
    $past(wr_i && addr_i == 2'd0 && wdata_i[4]) |-> (isr_o == '0 && mask_o == '0));

  a_r6_eoi_one_line: assert property (@(posedge clk) disable iff (rst)
    $past(wr_i && addr_i == 2'd0 && wdata_i[7:3] == 5'b00100 && isr_o != '0)
    |-> ($countones(isr_o) == $countones($past(isr_o)) - 1));

  a_r10_ack_data: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (rdata_o == {1'b1, {(7-LW){1'b0}}, ack_line_o}));

  a_r12_trig_masked: assert property (@(posedge clk) disable iff (rst)
    $past(wr_i && addr_i == 2'd2) |-> (trig_o == ($past(wdata_i) & TRIG_MASK)));

  a_r13_ack_needs_read: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(rd_i && !wr_i));
endmodule

bind pic_regif pic_regif_chk #(.TRIG_MASK(TRIG_MASK)) chk_i (
  .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i),
  .rd_i(rd_i), .rdata_o(rdata_o), .ack_o(ack_o), .ack_line_o(ack_line_o),
  .mask_o(mask_o), .isr_o(isr_o), .trig_o(trig_o));

// File: tb/pic_regif_tb_top.sv
module pic_regif_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0, rst = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, req = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata, mask, isr, vbase, trig;
  logic [2:0] ack_line, pbase;
  logic       ack, aeoi, rot, smm, nest;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_regif dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .req_i(req), .rdata_o(rdata), .ack_o(ack), .ack_line_o(ack_line),
    .mask_o(mask), .isr_o(isr), .prio_base_o(pbase), .vec_base_o(vbase),
    .trig_o(trig), .auto_eoi_o(aeoi), .rot_aeoi_o(rot), .spec_mask_o(smm),
    .nested_o(nest));

  task automatic chk(string req_tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req_tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data lands one cycle after the strobe
  always @(posedge clk) rd_d <= rd && !wr && !rst;
  always @(negedge clk) if (rd_d) begin
    if (exp_q.size() == 0) chk("R13 unexpected read", rdata, 8'hxx);
    else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, logic [7:0] exp, string t);
    exp_q.push_back(exp); tag_q.push_back(t);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic poll(logic [7:0] r, logic [7:0] exp, string t);
    req = r;
    wr_reg(2'd0, 8'h0C);
    rd_reg(2'd0, exp, t);
    chk({t, " ack"}, {7'd0, ack}, {7'd0, exp[7]});
    if (exp[7]) chk({t, " ack line"}, {5'd0, ack_line}, {5'd0, exp[2:0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    req = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 mask", mask, 0); chk("R1 isr", isr, 0); chk("R1 base", {5'd0, pbase}, 0);
    chk("R1 trig", trig, 0); chk("R1 modes", {4'd0, aeoi, rot, smm, nest}, 0);
    rd_reg(2'd0, 8'h5A, "R1 readback defaults to requests");

    // R12 trigger register
    wr_reg(2'd2, 8'hFF);
    chk("R12 trig masked", trig, 8'hF8);
    rd_reg(2'd2, 8'hF8, "R12 trig read");
    // R8 code 6 before init, R2 then clears it
    wr_reg(2'd0, 8'hC3);
    chk("R8 set priority", {5'd0, pbase}, 4);

    // R2/R3/R4: cascade, fourth word needed
    wr_reg(2'd0, 8'h11);
    chk("R2 base cleared", {5'd0, pbase}, 0);
    chk("R2 trig kept", trig, 8'hF8);
    wr_reg(2'd1, 8'h27);
    chk("R3 vector base", vbase, 8'h20);
    wr_reg(2'd1, 8'hAA);
    chk("R3 third word not mask", mask, 0);
    wr_reg(2'd1, 8'h12);
    chk("R4 auto eoi", {7'd0, aeoi}, 1); chk("R4 nested", {7'd0, nest}, 1);
    wr_reg(2'd1, 8'h3C);
    chk("R3 idle loads mask", mask, 8'h3C);
    rd_reg(2'd1, 8'h3C, "R12 mask read");

    // single, no fourth word
    wr_reg(2'd0, 8'h12);
    chk("R2 auto eoi cleared", {7'd0, aeoi}, 0);
    wr_reg(2'd1, 8'h48);
    chk("R3 vector base single", vbase, 8'h48);
    wr_reg(2'd1, 8'h81);
    chk("R3 single skips to idle", mask, 8'h81);

    // cascade, no fourth word
    wr_reg(2'd0, 8'h10);
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd1, 8'h55);
    chk("R3 third word ignored", mask, 0);
    wr_reg(2'd1, 8'h00);

    // R10 poll
    poll(8'h24, 8'h82, "R10 poll line 2");
    chk("R10 isr set", isr, 8'h04);
    poll(8'h24, 8'h00, "R10 poll loses to in-service");
    chk("R10 isr unchanged", isr, 8'h04);
    rd_reg(2'd0, 8'h24, "R10 poll disarmed");

    // R5 readback select
    wr_reg(2'd0, 8'h0B); rd_reg(2'd0, 8'h04, "R5 select isr");
    wr_reg(2'd0, 8'h08); rd_reg(2'd0, 8'h04, "R5 select kept");
    wr_reg(2'd0, 8'h0A); rd_reg(2'd0, 8'h24, "R5 select requests");

    // R6 non-specific EOI
    poll(8'h21, 8'h80, "R10 nested poll");
    chk("R10 two in service", isr, 8'h05);
    wr_reg(2'd0, 8'h20); chk("R6 clears line 0", isr, 8'h04);
    wr_reg(2'd0, 8'h20); chk("R6 clears line 2", isr, 8'h00);
    wr_reg(2'd0, 8'h20); chk("R6 empty no effect", isr, 8'h00);

    // rotation
    wr_reg(2'd0, 8'hC5); chk("R8 base 6", {5'd0, pbase}, 6);
    poll(8'h21, 8'h80, "R10 rotated winner");
    poll(8'h20, 8'h00, "R10 rotated lower loses");
    wr_reg(2'd0, 8'h60); chk("R8 specific eoi", isr, 8'h00);
    poll(8'h01, 8'h80, "R10 low first");
    poll(8'h40, 8'h86, "R10 high preempts");
    chk("R10 isr pair", isr, 8'h41);
    wr_reg(2'd0, 8'hA0);
    chk("R7 rotating eoi isr", isr, 8'h01); chk("R7 base", {5'd0, pbase}, 7);
    wr_reg(2'd0, 8'hE0);
    chk("R8 code 7 isr", isr, 8'h00); chk("R8 code 7 base", {5'd0, pbase}, 1);
    wr_reg(2'd0, 8'h40);
    chk("R8 code 2 base", {5'd0, pbase}, 1); chk("R8 code 2 isr", isr, 0);
    wr_reg(2'd0, 8'hA0);
    chk("R7 empty base kept", {5'd0, pbase}, 1);

    // special mask
    poll(8'h02, 8'h81, "R10 line 1");
    poll(8'h08, 8'h00, "R10 line 3 blocked");
    wr_reg(2'd1, 8'h02);
    wr_reg(2'd0, 8'h68); chk("R5 special mask on", {7'd0, smm}, 1);
    poll(8'h08, 8'h83, "R10 special mask lets line 3");
    chk("R10 isr with special mask", isr, 8'h0A);
    wr_reg(2'd0, 8'h48); chk("R5 special mask off", {7'd0, smm}, 0);

    // auto EOI with rotation
    wr_reg(2'd0, 8'h13); wr_reg(2'd1, 8'h00); wr_reg(2'd1, 8'h02);
    chk("R4 auto eoi single", {7'd0, aeoi}, 1);
    wr_reg(2'd0, 8'h80); chk("R9 rotate on", {7'd0, rot}, 1);
    poll(8'h10, 8'h84, "R11 poll auto eoi");
    chk("R11 isr untouched", isr, 0); chk("R11 base rotated", {5'd0, pbase}, 5);
    wr_reg(2'd0, 8'h00); chk("R9 rotate off", {7'd0, rot}, 0);
    poll(8'h10, 8'h84, "R11 poll no rotate");
    chk("R11 base kept", {5'd0, pbase}, 5);

    // R13 read coinciding with write
    wr_reg(2'd0, 8'h0C);
    @(negedge clk); addr = 2'd1; wdata = 8'h11; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    chk("R13 write wins", mask, 8'h11);
    chk("R13 no ack on write", {7'd0, ack}, 0);
    rd_reg(2'd0, 8'h00, "R13 poll still armed, masked");
    chk("R13 no ack masked", {7'd0, ack}, 0);
    rd_reg(2'd0, 8'h10, "R13 poll consumed");

    repeat (2) @(negedge clk);
    chk("R13 scoreboard drained", 8'(exp_q.size()), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule